// File: doc/BRIEF.md
# Bit-Addressed Parallel Port with Handshake Sequencer

This block is an 8-bit bidirectional parallel port that a host controls through a small bank of individually addressed control bits and one byte-wide data register. One bit sets the data direction. Two bits give the host the two auxiliary line pairs: a handshake pair and a spare pair. Writing such a bit sets the output line, and reading it returns the synchronised input line. The other bits give a card-enable output, an activity lamp and a loopback cell that lets software probe for the port's presence.

A hardware sequencer can take over the handshake line and run a complete four-phase transfer by itself, in either the sending role or the receiving role. While it runs, it forces the data direction to suit the role and it captures the incoming byte at the right phase. A host starts a transfer with a single pulse and then waits for a one-cycle completion pulse. An abort input stops the transfer at any wait point.

Top module: `pio_port`

## Requirements
- R1: While reset is applied, and after it is released, the port is an input (`pad_oe`=0). `hs_out` is 1. `spare_out`, `card_en`, `lamp`, `busy` and `done` are all 0.
- R2: Control bit 1 sets the direction: 1 means input and 0 means output. `pad_oe` equals the inverse of the bit while the sequencer is idle, and reading bit 1 returns the written value. In input direction, `byte_rd_data` follows `pad_in` one cycle later.
- R3: Reading control bit 2 returns `hs_in` after a two-flip-flop synchroniser. Writing bit 2 sets `hs_out` while the sequencer is idle.
- R4: Reading control bit 3 returns the synchronised `spare_in`. Writing bit 3 sets `spare_out`.
- R5: Control bit 4 is a loopback cell: a read returns the last value written.
- R6: Control bit 0 always reads 0. Writing it sets `card_en` to the written value.
- R7: Control bit 7 sets `lamp` and reads back its state. Bits 5 and 6 read 0, and writes to them have no effect.
- R8: A byte write loads the output latch (`pad_out`) only when bit 1 is 0. In input direction a byte write is ignored.
- R9: The sender sequence works as follows. A `tx_start` pulse makes the port drive the output latch, with `hs_out` held at 1. Once the synchronised `hs_in` is low, `hs_out` goes low. Once `hs_in` is high again, `hs_out` returns high and the sequence ends.
- R10: The receiver sequence works as follows. An `rx_start` pulse drives `hs_out` low. When the synchronised `hs_in` goes low, the port captures `pad_in` into the input latch and drives `hs_out` high. Once `hs_in` is high, the sequence ends. The captured byte stays in the latch while the pins change.
- R11: `busy` is 1 from the cycle after a start until the sequence ends. `done` is then a single-cycle pulse, in the same cycle that `busy` falls. A start while busy is ignored. When both start inputs arrive together, `tx_start` wins.
- R12: `abort` during a sequence returns the sequencer to idle on the next edge, with no `done` pulse.
- R13: During a sequence, the sequencer owns `hs_out` and the data direction: a send drives the pins and a receive never does. A bit-2 write during the sequence shows on `hs_out` only after the sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_addr | input | 3 | Control bit select |
| bit_wr | input | 1 | Control bit write strobe |
| bit_wr_data | input | 1 | Control bit write value |
| bit_rd_data | output | 1 | Selected control bit read value |
| byte_wr | input | 1 | Data byte write strobe |
| byte_wr_data | input | 8 | Data byte to output latch |
| byte_rd_data | output | 8 | Input latch contents |
| pad_in | input | 8 | Data pins, input side |
| pad_out | output | 8 | Data pins, output latch |
| pad_oe | output | 1 | Data pin drive enable |
| hs_in | input | 1 | Handshake input line |
| hs_out | output | 1 | Handshake output line |
| spare_in | input | 1 | Spare input line |
| spare_out | output | 1 | Spare output line |
| card_en | output | 1 | Card enable |
| lamp | output | 1 | Activity lamp |
| tx_start | input | 1 | Start a sender sequence |
| rx_start | input | 1 | Start a receiver sequence |
| abort | input | 1 | Abandon the running sequence |
| busy | output | 1 | Sequence running |
| done | output | 1 | Sequence finished pulse |

## Verification
The hardest states to reach are inside a running sequence, where `hs_out` and the direction belong to the sequencer and not to the control bits. The stimulus acts as the remote partner. It holds `hs_in` at each level long enough for the synchroniser, and it checks the line state after each phase. Within those phases it adds a competing start, a bit-2 write, pin changes after the capture, and an abort. Random control-bit and byte traffic with random pin levels covers the register bank against a bench model.

// File: rtl/pio_pkg.sv
`timescale 1ns/1ps
package pio_pkg;
  // control bit positions (software-visible map)
  localparam int unsigned BIT_ENABLE = 0;
  localparam int unsigned BIT_DIR    = 1;
  localparam int unsigned BIT_HS     = 2;
  localparam int unsigned BIT_SPARE  = 3;
  localparam int unsigned BIT_LOOP   = 4;
  localparam int unsigned BIT_LAMP   = 7;

  typedef enum logic [2:0] {
    HS_IDLE        = 3'd0,
    HS_TX_WAIT_RDY = 3'd1,
    HS_TX_WAIT_ACK = 3'd2,
    HS_RX_WAIT_SNT = 3'd3,
    HS_RX_WAIT_IDL = 3'd4
  } hs_state_e;
endpackage

// File: rtl/pio_sync.sv
`timescale 1ns/1ps
module pio_sync #(
  parameter int unsigned    WIDTH   = 1,
  parameter int unsigned    STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar gs = 0; gs < STAGES; gs++) begin : g_stage
    if (gs == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[gs] <= RST_VAL;
        else        stage_q[gs] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[gs] <= RST_VAL;
        else        stage_q[gs] <= stage_q[gs-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pio_ctrl_bits.sv
`timescale 1ns/1ps
module pio_ctrl_bits
  import pio_pkg::*;
#(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] addr,
  input  logic             wr,
  input  logic             wr_data,
  input  logic             hs_level,
  input  logic             spare_level,
  output logic             rd_data,
  output logic             card_en,
  output logic             dir_in,
  output logic             hs_sw,
  output logic             spare_out,
  output logic             lamp
);
  logic en_card, en_dir, en_hs, en_spare, en_loop, en_lamp;
  logic loop_q;

  // write decode: one clock enable per stored bit
  always_comb begin
    en_card  = wr && (addr == SEL_W'(BIT_ENABLE));
    en_dir   = wr && (addr == SEL_W'(BIT_DIR));
    en_hs    = wr && (addr == SEL_W'(BIT_HS));
    en_spare = wr && (addr == SEL_W'(BIT_SPARE));
    en_loop  = wr && (addr == SEL_W'(BIT_LOOP));
    en_lamp  = wr && (addr == SEL_W'(BIT_LAMP));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      card_en   <= 1'b0;
      dir_in    <= 1'b1;
      hs_sw     <= 1'b1;
      spare_out <= 1'b0;
      loop_q    <= 1'b0;
      lamp      <= 1'b0;
    end else begin
      if (en_card)  card_en   <= wr_data;
      if (en_dir)   dir_in    <= wr_data;
      if (en_hs)    hs_sw     <= wr_data;
      if (en_spare) spare_out <= wr_data;
      if (en_loop)  loop_q    <= wr_data;
      if (en_lamp)  lamp      <= wr_data;
    end
  end

  // read side: the same address has a different meaning for bits 2 and 3
  always_comb begin
    rd_data = 1'b0;
    if      (addr == SEL_W'(BIT_DIR))   rd_data = dir_in;
    else if (addr == SEL_W'(BIT_HS))    rd_data = hs_level;
    else if (addr == SEL_W'(BIT_SPARE)) rd_data = spare_level;
    else if (addr == SEL_W'(BIT_LOOP))  rd_data = loop_q;
    else if (addr == SEL_W'(BIT_LAMP))  rd_data = lamp;
  end
endmodule

// File: rtl/pio_hs_engine.sv
`timescale 1ns/1ps
module pio_hs_engine
  import pio_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tx_start,
  input  logic rx_start,
  input  logic abort,
  input  logic hs_level,
  output logic busy,
  output logic tx_active,
  output logic rx_active,
  output logic hs_drive,
  output logic capture,
  output logic done
);
  hs_state_e state_q, state_d;
  logic      done_d;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    capture = 1'b0;
    unique case (state_q)
      HS_IDLE: begin
        if      (tx_start) state_d = HS_TX_WAIT_RDY;
        else if (rx_start) state_d = HS_RX_WAIT_SNT;
      end
      HS_TX_WAIT_RDY: begin
        if      (abort)     state_d = HS_IDLE;
        else if (!hs_level) state_d = HS_TX_WAIT_ACK;
      end
      HS_TX_WAIT_ACK: begin
        if (abort) state_d = HS_IDLE;
        else if (hs_level) begin
          state_d = HS_IDLE;
          done_d  = 1'b1;
        end
      end
      HS_RX_WAIT_SNT: begin
        if (abort) state_d = HS_IDLE;
        else if (!hs_level) begin
          state_d = HS_RX_WAIT_IDL;
          capture = 1'b1;
        end
      end
      HS_RX_WAIT_IDL: begin
        if (abort) state_d = HS_IDLE;
        else if (hs_level) begin
          state_d = HS_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= done_d;
    end
  end

  always_comb begin
    busy      = (state_q != HS_IDLE);
    tx_active = (state_q == HS_TX_WAIT_RDY) || (state_q == HS_TX_WAIT_ACK);
    rx_active = (state_q == HS_RX_WAIT_SNT) || (state_q == HS_RX_WAIT_IDL);
    hs_drive  = !((state_q == HS_TX_WAIT_ACK) || (state_q == HS_RX_WAIT_SNT));
  end
endmodule

// File: rtl/pio_data_path.sv
`timescale 1ns/1ps
module pio_data_path #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_in,
  input  logic              tx_active,
  input  logic              rx_active,
  input  logic              capture,
  input  logic              byte_wr,
  input  logic [DATA_W-1:0] byte_wr_data,
  input  logic [DATA_W-1:0] pad_in,
  output logic [DATA_W-1:0] pad_out,
  output logic              pad_oe,
  output logic [DATA_W-1:0] byte_rd_data
);
  logic out_en, in_en;
  logic [DATA_W-1:0] out_q, in_q;

  always_comb begin
    pad_oe = tx_active || (!rx_active && !dir_in);
    out_en = byte_wr && !dir_in;
    in_en  = capture || (!rx_active && !tx_active && dir_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      in_q  <= '0;
    end else begin
      if (out_en) out_q <= byte_wr_data;
      if (in_en)  in_q  <= pad_in;
    end
  end

  assign pad_out      = out_q;
  assign byte_rd_data = in_q;
endmodule

// File: rtl/pio_port.sv
`timescale 1ns/1ps
module pio_port #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  bit_addr,
  input  logic              bit_wr,
  input  logic              bit_wr_data,
  output logic              bit_rd_data,
  input  logic              byte_wr,
  input  logic [DATA_W-1:0] byte_wr_data,
  output logic [DATA_W-1:0] byte_rd_data,
  input  logic [DATA_W-1:0] pad_in,
  output logic [DATA_W-1:0] pad_out,
  output logic              pad_oe,
  input  logic              hs_in,
  output logic              hs_out,
  input  logic              spare_in,
  output logic              spare_out,
  output logic              card_en,
  output logic              lamp,
  input  logic              tx_start,
  input  logic              rx_start,
  input  logic              abort,
  output logic              busy,
  output logic              done
);
  localparam int unsigned LINES = 2;

  logic [1:0]       rst_pipe_q;
  logic             rst_sync_q;
  logic [LINES-1:0] lines_async, lines_sync;
  logic             hs_level, spare_level;
  logic             dir_in, hs_sw;
  logic             tx_active, rx_active, hs_drive, capture;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_q = rst_pipe_q[1];

  assign lines_async = {spare_in, hs_in};

  pio_sync #(.WIDTH(LINES), .STAGES(SYNC_STGS), .RST_VAL(2'b01)) sync_i (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .d     (lines_async),
    .q     (lines_sync)
  );
  assign hs_level    = lines_sync[0];
  assign spare_level = lines_sync[1];

  pio_ctrl_bits #(.SEL_W(SEL_W)) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .addr        (bit_addr),
    .wr          (bit_wr),
    .wr_data     (bit_wr_data),
    .hs_level    (hs_level),
    .spare_level (spare_level),
    .rd_data     (bit_rd_data),
    .card_en     (card_en),
    .dir_in      (dir_in),
    .hs_sw       (hs_sw),
    .spare_out   (spare_out),
    .lamp        (lamp)
  );

  pio_hs_engine eng_i (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .tx_start  (tx_start),
    .rx_start  (rx_start),
    .abort     (abort),
    .hs_level  (hs_level),
    .busy      (busy),
    .tx_active (tx_active),
    .rx_active (rx_active),
    .hs_drive  (hs_drive),
    .capture   (capture),
    .done      (done)
  );

  pio_data_path #(.DATA_W(DATA_W)) dp_i (
    .clk          (clk),
    .rst_n        (rst_sync_q),
    .dir_in       (dir_in),
    .tx_active    (tx_active),
    .rx_active    (rx_active),
    .capture      (capture),
    .byte_wr      (byte_wr),
    .byte_wr_data (byte_wr_data),
    .pad_in       (pad_in),
    .pad_out      (pad_out),
    .pad_oe       (pad_oe),
    .byte_rd_data (byte_rd_data)
  );

  assign hs_out = busy ? hs_drive : hs_sw;
endmodule

// File: rtl/pio_port_chk.sv
`timescale 1ns/1ps
module pio_port_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SEL_W  = 3
) (
  input logic              clk,
  input logic              rst_q,
  input logic [SEL_W-1:0]  bit_addr,
  input logic              bit_wr,
  input logic              bit_wr_data,
  input logic              bit_rd_data,
  input logic              byte_wr,
  input logic [DATA_W-1:0] pad_out,
  input logic              pad_oe,
  input logic              dir_in,
  input logic              busy,
  input logic              done,
  input logic              abort,
  input logic              card_en,
  input logic              rx_active
);
  // R6
  card_write_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (bit_wr && bit_addr == SEL_W'(0)) |=> (card_en == $past(bit_wr_data)));

  // R5
  loop_readback_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (bit_wr && bit_addr == SEL_W'(4)) |=>
      (bit_addr != SEL_W'(4) || bit_rd_data == $past(bit_wr_data)));

  // R8
  input_dir_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (byte_wr && dir_in) |=> $stable(pad_out));

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_q)
    done |=> !done);

  // R11
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_q)
    done |-> (!busy && $past(busy)));

  // R12
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (busy && abort) |=> !busy);

  // R13
  rx_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_q)
    rx_active |-> !pad_oe);
endmodule

bind pio_port pio_port_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) chk_i (
  .clk         (clk),
  .rst_q       (rst_sync_q),
  .bit_addr    (bit_addr),
  .bit_wr      (bit_wr),
  .bit_wr_data (bit_wr_data),
  .bit_rd_data (bit_rd_data),
  .byte_wr     (byte_wr),
  .pad_out     (pad_out),
  .pad_oe      (pad_oe),
  .dir_in      (dir_in),
  .busy        (busy),
  .done        (done),
  .abort       (abort),
  .card_en     (card_en),
  .rx_active   (rx_active)
);

// File: tb/pio_port_tb_top.sv
`timescale 1ns/1ps
module pio_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bit_addr = '0;
  logic       bit_wr = 1'b0, bit_wr_data = 1'b0, bit_rd_data;
  logic       byte_wr = 1'b0;
  logic [7:0] byte_wr_data = '0, byte_rd_data, pad_in = '0, pad_out;
  logic       pad_oe, hs_in = 1'b1, hs_out, spare_in = 1'b0, spare_out;
  logic       card_en, lamp, tx_start = 1'b0, rx_start = 1'b0, abort = 1'b0;
  logic       busy, done;

  int checks = 0, errors = 0, done_cnt = 0;
  bit finished = 0;

  // bench model of the stored bits
  logic m_card, m_dir, m_hs, m_spare, m_loop, m_lamp;
  logic [7:0] m_out;

  always #10 clk = ~clk;

  pio_port dut_i (
    .clk(clk), .rst_n(rst_n), .bit_addr(bit_addr), .bit_wr(bit_wr),
    .bit_wr_data(bit_wr_data), .bit_rd_data(bit_rd_data), .byte_wr(byte_wr),
    .byte_wr_data(byte_wr_data), .byte_rd_data(byte_rd_data), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .hs_in(hs_in), .hs_out(hs_out),
    .spare_in(spare_in), .spare_out(spare_out), .card_en(card_en), .lamp(lamp),
    .tx_start(tx_start), .rx_start(rx_start), .abort(abort), .busy(busy), .done(done)
  );

  always @(negedge clk) if (done) done_cnt++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wbit(input logic [2:0] a, input logic d);
    @(negedge clk);
    bit_addr = a; bit_wr = 1'b1; bit_wr_data = d;
    @(negedge clk);
    bit_wr = 1'b0;
    case (a)
      3'd0: m_card = d;
      3'd1: m_dir = d;
      3'd2: m_hs = d;
      3'd3: m_spare = d;
      3'd4: m_loop = d;
      3'd7: m_lamp = d;
      default: ;
    endcase
  endtask

  task automatic wbyte(input logic [7:0] d);
    @(negedge clk);
    byte_wr = 1'b1; byte_wr_data = d;
    @(negedge clk);
    byte_wr = 1'b0;
    if (!m_dir) m_out = d;
  endtask

  task automatic pulse_tx(); @(negedge clk); tx_start = 1; @(negedge clk); tx_start = 0; endtask
  task automatic pulse_rx(); @(negedge clk); rx_start = 1; @(negedge clk); rx_start = 0; endtask

  function automatic logic exp_bit(input logic [2:0] a);
    case (a)
      3'd1: return m_dir;
      3'd2: return hs_in;
      3'd3: return spare_in;
      3'd4: return m_loop;
      3'd7: return m_lamp;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string bit_req(input logic [2:0] a);
    case (a)
      3'd0: return "R6";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic check_all_bits();
    for (int a = 0; a < 8; a++) begin
      bit_addr = 3'(a);
      #1;
      check(bit_req(3'(a)), 32'(bit_rd_data), 32'(exp_bit(3'(a))));
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    int dc;
    void'($urandom(32'h1F2E3D4C));
    m_card = 0; m_dir = 1; m_hs = 1; m_spare = 0; m_loop = 0; m_lamp = 0; m_out = '0;
    cyc(2);
    // R1 reset state during reset
    check("R1", {pad_oe, hs_out, spare_out, card_en, lamp, busy, done}, 7'b0100000);
    rst_n = 1'b1;
    cyc(5);
    check("R1", {pad_oe, hs_out, spare_out, card_en, lamp, busy, done}, 7'b0100000);

    // random control bit and byte traffic
    for (int it = 0; it < 300; it++) begin
      int op;
      @(negedge clk);
      hs_in = 1'($urandom); spare_in = 1'($urandom); pad_in = 8'($urandom);
      op = $urandom % 4;
      if (op < 2) wbit(3'($urandom), 1'($urandom));
      else if (op == 2) wbyte(8'($urandom));
      cyc(3);
      check_all_bits();
      check("R2", 32'(pad_oe), 32'(!m_dir));
      check("R3", 32'(hs_out), 32'(m_hs));
      check("R4", 32'(spare_out), 32'(m_spare));
      check("R6", 32'(card_en), 32'(m_card));
      check("R7", 32'(lamp), 32'(m_lamp));
      check("R8", 32'(pad_out), 32'(m_out));
      if (m_dir) check("R2", 32'(byte_rd_data), 32'(pad_in));
    end

    // directed: input-direction byte write ignored
    wbit(3'd2, 1'b1); wbit(3'd1, 1'b0); wbyte(8'h5A);
    wbit(3'd1, 1'b1); wbyte(8'hC3);
    check("R8", 32'(pad_out), 32'h5A);
    wbit(3'd5, 1'b1); wbit(3'd6, 1'b1);
    bit_addr = 3'd5; #1; check("R7", 32'(bit_rd_data), 0);
    bit_addr = 3'd6; #1; check("R7", 32'(bit_rd_data), 0);

    // sender sequence, direction forced to output
    wbit(3'd1, 1'b0); wbyte(8'hA5); wbit(3'd1, 1'b1);
    hs_in = 1'b1; cyc(3);
    dc = done_cnt;
    pulse_tx(); cyc(3);
    check("R9", {busy, hs_out, pad_oe}, 3'b111);
    check("R9", 32'(pad_out), 32'hA5);
    pulse_rx(); cyc(1);  // ignored while busy
    check("R11", {busy, pad_oe, hs_out}, 3'b111);
    hs_in = 1'b0; cyc(4);
    check("R9", {busy, hs_out}, 2'b10);
    hs_in = 1'b1; cyc(8);
    check("R11", 32'(done_cnt - dc), 1);
    check("R9", {busy, hs_out, pad_oe}, 3'b010);

    // receiver sequence with output direction selected in software
    wbit(3'd1, 1'b0);
    dc = done_cnt;
    pulse_rx(); cyc(3);
    check("R13", {busy, hs_out, pad_oe}, 3'b100);
    pad_in = 8'h3C; cyc(1); hs_in = 1'b0; cyc(4);
    check("R10", {busy, hs_out}, 2'b11);
    check("R10", 32'(byte_rd_data), 32'h3C);
    pad_in = 8'hFF;
    wbit(3'd2, 1'b0); cyc(1);
    check("R13", 32'(hs_out), 1);
    check("R10", 32'(byte_rd_data), 32'h3C);
    hs_in = 1'b1; cyc(8);
    check("R11", 32'(done_cnt - dc), 1);
    check("R13", {busy, hs_out, pad_oe}, 3'b001);
    check("R10", 32'(byte_rd_data), 32'h3C);
    wbit(3'd2, 1'b1);

    // simultaneous starts: sender wins
    @(negedge clk); tx_start = 1; rx_start = 1; @(negedge clk); tx_start = 0; rx_start = 0;
    cyc(2);
    check("R11", {busy, pad_oe, hs_out}, 3'b111);
    // abort with no done
    dc = done_cnt;
    @(negedge clk); abort = 1; @(negedge clk); abort = 0;
    cyc(2);
    check("R12", {busy, 31'(done_cnt - dc)}, 0);

    // abort of receiver mid-sequence
    pulse_rx(); cyc(2);
    check("R12", 32'(busy), 1);
    @(negedge clk); abort = 1; @(negedge clk); abort = 0;
    cyc(1);
    check("R12", {busy, hs_out}, 2'b01);

    finished = 1;
    summary();
    $finish;
  end
endmodule